// File: doc/BRIEF.md
# Status-Flag Arithmetic and Logic Unit

This is a purely combinational 8-bit arithmetic and logic unit for a small accumulator-style processor. On every cycle the surrounding datapath presents an operation code, a register operand (the accumulator or an index register) and a memory operand. It also presents the current carry flag. The unit returns a data result together with candidate values for the negative, zero, carry and overflow flags.

Every output value comes with its own enable. The status register beside the unit loads only the flags whose enable is high and holds the others. The result-write strobe tells the datapath whether the result should be stored at all. Compare and bit test never store a result. Add and subtract are always binary.

The single-operand operations work on the memory operand: increment, decrement, the two shifts and the two rotates. To use the accumulator form of one of these, the datapath routes the accumulator onto the memory operand.

Top module: `flag_alu`

## Requirements
- R1: Codes 0 (OR), 1 (AND), 2 (XOR) and 3 (load, result = M) produce the bitwise result of R and M. For these codes `res_we` is 1, `n_we` and `z_we` are 1, and `c_we` and `v_we` are 0.
- R2: Code 4 (add) gives result = low 8 bits of R + M + carry_in. `c_out` is 1 exactly when that sum exceeds 0xFF, and `c_we` is 1.
- R3: For code 4, `v_out` is 1 exactly when R and M share bit 7 and the result's bit 7 differs from R's. `v_we` is 1.
- R4: Code 5 (subtract) gives result = low 8 bits of R − M − (1 − carry_in). `c_out` is 1 exactly when that difference is not negative, and `c_we` is 1.
- R5: For code 5, `v_out` is 1 exactly when R and M differ in bit 7 and the result's bit 7 differs from R's. `v_we` is 1.
- R6: Code 6 (compare) has `res_we` = 0 and `v_we` = 0. It sets `c_out` = (R ≥ M unsigned), `z_out` = (R == M) and `n_out` = bit 7 of R − M, with `n_we`, `z_we` and `c_we` all 1.
- R7: Code 7 (bit test) has `res_we` = 0 and `c_we` = 0. It sets `z_out` = ((R AND M) == 0), `n_out` = M bit 7 and `v_out` = M bit 6, with `n_we`, `z_we` and `v_we` all 1.
- R8: Codes 8 (increment) and 9 (decrement) give M + 1 and M − 1 modulo 256. They have `res_we` = 1, `n_we` and `z_we` = 1, and `c_we` = `v_we` = 0.
- R9: Code 10 (shift left) gives {M[6:0],0} and code 11 (logical shift right) gives {0,M[7:1]}. `c_out` takes the bit shifted out, and `c_we` = 1, `v_we` = 0.
- R10: Code 12 (rotate left) gives {M[6:0],carry_in} and code 13 (rotate right) gives {carry_in,M[7:1]}. `c_out` takes the bit rotated out, and `c_we` = 1, `v_we` = 0.
- R11: Codes 14 and 15 are unused. For them `res_we` and all four flag enables are 0.
- R12: Whenever `res_we` is 1, `n_out` equals bit 7 of the result and `z_out` is 1 exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code, encoded as listed in the requirements |
| reg_in | input | 8 | Register operand R |
| mem_in | input | 8 | Memory operand M |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Data result |
| res_we | output | 1 | Result is to be stored |
| n_out | output | 1 | Next negative flag |
| n_we | output | 1 | Load negative flag |
| z_out | output | 1 | Next zero flag |
| z_we | output | 1 | Load zero flag |
| c_out | output | 1 | Next carry flag |
| c_we | output | 1 | Load carry flag |
| v_out | output | 1 | Next overflow flag |
| v_we | output | 1 | Load overflow flag |

## Verification
Carry and overflow are both produced in the same evaluation of an add or a subtract, and they come from different parts of the sum. The bench provokes cases where both are set, where only one is set, and where neither is set. It does this with operand corners such as 0x7F, 0x80 and 0xFF, taken with both carry-in values, plus random pairs. A behavioural integer model judges each flag independently on every clock.

Compare and bit test likewise raise a zero flag together with a carry or overflow flag while suppressing the result write. Here the bench checks that each enable matches the rule for that operation.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] reg_in,
  input  logic [WIDTH-1:0] mem_in,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             res_we,
  output logic             n_out,
  output logic             n_we,
  output logic             z_out,
  output logic             z_we,
  output logic             c_out,
  output logic             c_we,
  output logic             v_out,
  output logic             v_we
);
  localparam int S = WIDTH - 1;
  localparam logic [3:0] OP_OR = 4'd0, OP_AND = 4'd1, OP_XOR = 4'd2, OP_LD = 4'd3,
                         OP_ADD = 4'd4, OP_SUB = 4'd5, OP_CMP = 4'd6, OP_BIT = 4'd7,
                         OP_INC = 4'd8, OP_DEC = 4'd9, OP_SHL = 4'd10, OP_SHR = 4'd11,
                         OP_ROL = 4'd12, OP_ROR = 4'd13;

  logic [WIDTH:0]   sum;
  logic [WIDTH-1:0] res;
  logic             nz_from_res;
  logic             n_alt, z_alt;

  // Add, subtract and compare share one adder; subtraction adds the complement.
  always_comb begin
    case (op)
      OP_ADD:  sum = {1'b0, reg_in} + {1'b0, mem_in}  + {{WIDTH{1'b0}}, carry_in};
      OP_SUB:  sum = {1'b0, reg_in} + {1'b0, ~mem_in} + {{WIDTH{1'b0}}, carry_in};
      OP_CMP:  sum = {1'b0, reg_in} + {1'b0, ~mem_in} + {{WIDTH{1'b0}}, 1'b1};
      default: sum = '0;
    endcase
  end

  always_comb begin
    res         = '0;
    res_we      = 1'b0;
    nz_from_res = 1'b0;
    n_alt       = 1'b0;
    z_alt       = 1'b0;
    n_we        = 1'b0;
    z_we        = 1'b0;
    c_out       = 1'b0;
    c_we        = 1'b0;
    v_out       = 1'b0;
    v_we        = 1'b0;
    case (op)
      OP_OR, OP_AND, OP_XOR, OP_LD: begin
        case (op)
          OP_OR:   res = reg_in | mem_in;
          OP_AND:  res = reg_in & mem_in;
          OP_XOR:  res = reg_in ^ mem_in;
          default: res = mem_in;
        endcase
        res_we = 1'b1; nz_from_res = 1'b1;
      end
      OP_ADD: begin
        res    = sum[S:0];
        res_we = 1'b1; nz_from_res = 1'b1;
        c_out  = sum[WIDTH]; c_we = 1'b1;
        v_out  = (reg_in[S] == mem_in[S]) && (sum[S] != reg_in[S]); v_we = 1'b1;
      end
      OP_SUB: begin
        res    = sum[S:0];
        res_we = 1'b1; nz_from_res = 1'b1;
        c_out  = sum[WIDTH]; c_we = 1'b1;
        v_out  = (reg_in[S] != mem_in[S]) && (sum[S] != reg_in[S]); v_we = 1'b1;
      end
      OP_CMP: begin
        n_alt = sum[S];
        z_alt = (reg_in == mem_in);
        c_out = sum[WIDTH]; c_we = 1'b1;
      end
      OP_BIT: begin
        n_alt = mem_in[S];
        z_alt = ((reg_in & mem_in) == '0);
        v_out = mem_in[S-1]; v_we = 1'b1;
      end
      OP_INC, OP_DEC: begin
        res    = (op == OP_INC) ? mem_in + 1'b1 : mem_in - 1'b1;
        res_we = 1'b1; nz_from_res = 1'b1;
      end
      OP_SHL, OP_ROL: begin
        res    = {mem_in[S-1:0], (op == OP_ROL) ? carry_in : 1'b0};
        res_we = 1'b1; nz_from_res = 1'b1;
        c_out  = mem_in[S]; c_we = 1'b1;
      end
      OP_SHR, OP_ROR: begin
        res    = {(op == OP_ROR) ? carry_in : 1'b0, mem_in[S:1]};
        res_we = 1'b1; nz_from_res = 1'b1;
        c_out  = mem_in[0]; c_we = 1'b1;
      end
      default: ;
    endcase
    if (op == OP_CMP || op == OP_BIT) begin
      n_we = 1'b1; z_we = 1'b1;
    end else if (nz_from_res) begin
      n_we = 1'b1; z_we = 1'b1;
    end
  end

  assign result = res;
  assign n_out  = nz_from_res ? res[S] : n_alt;
  assign z_out  = nz_from_res ? (res == '0) : z_alt;
endmodule

module flag_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic [3:0]       op,
  input logic [WIDTH-1:0] reg_in,
  input logic [WIDTH-1:0] mem_in,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             res_we,
  input logic             n_out,
  input logic             n_we,
  input logic             z_out,
  input logic             z_we,
  input logic             c_out,
  input logic             c_we,
  input logic             v_out,
  input logic             v_we
);
  localparam int S = WIDTH - 1;
  logic known;
  assign known = !$isunknown({op, reg_in, mem_in, carry_in});

  always_comb begin
    if (known) begin
      // R12
      nz_rule_chk: assert (!res_we || (n_out == result[S] && z_out == (result == '0)));
      // R6
      cmp_no_write_chk: assert (op != 4'd6 || (!res_we && !v_we && c_we && n_we && z_we));
      // R7
      bit_no_carry_chk: assert (op != 4'd7 || (!res_we && !c_we && v_we && n_out == mem_in[S]));
      // R8
      incdec_keep_cv_chk: assert (!(op == 4'd8 || op == 4'd9) || (!c_we && !v_we && res_we));
      // R11
      unused_quiet_chk: assert (op < 4'd14 || !(res_we || n_we || z_we || c_we || v_we));
      // R2
      add_carry_chk: assert (op != 4'd4 || !c_out || result < reg_in || (result == reg_in && carry_in));
    end
  end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op = '0;
  logic [7:0] reg_in = '0, mem_in = '0;
  logic       carry_in = 1'b0;
  logic [7:0] result;
  logic       res_we, n_out, n_we, z_out, z_we, c_out, c_we, v_out, v_we;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  flag_alu uut (.op(op), .reg_in(reg_in), .mem_in(mem_in), .carry_in(carry_in),
    .result(result), .res_we(res_we), .n_out(n_out), .n_we(n_we), .z_out(z_out),
    .z_we(z_we), .c_out(c_out), .c_we(c_we), .v_out(v_out), .v_we(v_we));

  function automatic string tag(int o);
    case (o)
      0, 1, 2, 3: return "R1";
      4:          return "R2/R3";
      5:          return "R4/R5";
      6:          return "R6";
      7:          return "R7";
      8, 9:       return "R8";
      10, 11:     return "R9";
      12, 13:     return "R10";
      default:    return "R11";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%0d R=%02h M=%02h C=%0d actual=%0h expected=%0h",
               req, what, op, reg_in, mem_in, carry_in, act, exp);
    end
  endtask

  task automatic judge();
    int r = reg_in, m = mem_in, c = carry_in, o = op;
    int res = 0, s;
    bit wr = 0, nw = 0, zw = 0, cw = 0, vw = 0, no = 0, zo = 0, co = 0, vo = 0;
    case (o)
      0: begin res = r | m; wr = 1; end
      1: begin res = r & m; wr = 1; end
      2: begin res = r ^ m; wr = 1; end
      3: begin res = m; wr = 1; end
      4: begin s = r + m + c; res = s % 256; wr = 1; cw = 1; co = s > 255;
               vw = 1; vo = ((r ^ m) & 128) == 0 && ((r ^ res) & 128) != 0; end
      5: begin s = r - m - (1 - c); res = (s + 512) % 256; wr = 1; cw = 1; co = s >= 0;
               vw = 1; vo = ((r ^ m) & 128) != 0 && ((r ^ res) & 128) != 0; end
      6: begin nw = 1; zw = 1; cw = 1; co = r >= m; zo = r == m;
               no = ((r - m + 256) % 256) >= 128; end
      7: begin nw = 1; zw = 1; vw = 1; zo = (r & m) == 0; no = m >= 128; vo = (m & 64) != 0; end
      8:  begin res = (m + 1) % 256; wr = 1; end
      9:  begin res = (m + 255) % 256; wr = 1; end
      10: begin res = (m * 2) % 256; wr = 1; cw = 1; co = m >= 128; end
      11: begin res = m / 2; wr = 1; cw = 1; co = m % 2; end
      12: begin res = (m * 2) % 256 + c; wr = 1; cw = 1; co = m >= 128; end
      13: begin res = m / 2 + c * 128; wr = 1; cw = 1; co = m % 2; end
      default: ;
    endcase
    if (wr) begin nw = 1; zw = 1; no = res >= 128; zo = res == 0; end
    chk(tag(o), "enables", {res_we, n_we, z_we, c_we, v_we}, {wr, nw, zw, cw, vw});
    if (wr) chk(tag(o), "result", result, res);
    if (wr) chk("R12", "n/z from result", {n_out, z_out}, {no, zo});
    else if (nw) chk(tag(o), "n/z", {n_out, z_out}, {no, zo});
    if (cw) chk(tag(o), "carry", c_out, co);
    if (vw) chk(tag(o), "overflow", v_out, vo);
  endtask

  task automatic apply(int o, int r, int m, int c);
    @(posedge clk);
    #1;
    op = o[3:0]; reg_in = r[7:0]; mem_in = m[7:0]; carry_in = c[0];
    @(negedge clk);
    judge();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int corner[7] = '{8'h00, 8'h01, 8'h40, 8'h7F, 8'h80, 8'hFF, 8'h55};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    judge();
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          for (int c = 0; c < 2; c++)
            apply(o, corner[i], corner[j], c);
    // carry and overflow together / separately
    apply(4, 8'h80, 8'h80, 0);
    apply(4, 8'h7F, 8'h00, 1);
    apply(4, 8'hFF, 8'h01, 0);
    apply(5, 8'h80, 8'h01, 1);
    apply(5, 8'h00, 8'h00, 0);
    apply(5, 8'h7F, 8'hFF, 1);
    apply(6, 8'h10, 8'h10, 0);
    apply(7, 8'hC0, 8'h3F, 1);
    for (int k = 0; k < 4000; k++)
      apply($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255),
            $urandom_range(0, 1));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule